// File: doc/BRIEF.md
# Compressed Branch Trace Nibble Serializer

This block carries branch destination addresses from a processor core to an off-chip trace port. The core offers one address for each taken branch or interrupt. The block sends it over a four-bit data bus, together with a sync strobe and a forwarded trace clock that runs at half the system clock. When nothing is being sent, the bus carries a fixed idle nibble.

To save port bandwidth, each address is compared with the last address that went out completely. Only the low part that differs is sent, as a group of 1, 2, 4 or 8 nibbles. A header nibble comes first and tells the receiver which group size follows.

A one-entry holding slot lets the core post a new event while a transfer is still running. A ready output shows when that slot is full. A sticky flag records any event that was offered while the slot was full and was therefore dropped.

Top module: `trace_nibble_tx`

## Requirements
- R1: `trc_clk` toggles on every system clock cycle after reset. `trc_sync` and `trc_data` change only on the cycle in which `trc_clk` falls, so each bus value is stable while `trc_clk` is high.
- R2: While no transfer is under way, `trc_sync` is 1 and `trc_data` is 4'b0011.
- R3: A transfer opens with one header nibble sent with `trc_sync` = 1. Header bits [3:2] are 2'b10 and bits [1:0] hold the size code. The address nibbles that follow are sent with `trc_sync` = 0.
- R4: The size code is chosen from the new address and the reference address. It is 2'b00 when bits [31:4] are equal, otherwise 2'b01 when bits [31:8] are equal, otherwise 2'b10 when bits [31:16] are equal, otherwise 2'b11. The smallest matching group always wins.
- R5: Size codes 00, 01, 10 and 11 are followed by exactly 1, 2, 4 and 8 address nibbles.
- R6: Address nibbles go out least significant first: bits [3:0], then [7:4], and so on upward.
- R7: The reference address takes the new value only after that address's last nibble has been sent. After reset the reference is invalid, so the first transfer always uses size code 2'b11.
- R8: `br_ready` is 1 exactly when the holding slot is empty. When `br_valid` is 1 and `br_ready` is 1, the event is captured, and every captured event is later transmitted.
- R9: `br_ovf` starts at 0 after reset. It becomes 1, and stays 1 until reset, when `br_valid` is 1 while `br_ready` is 0; such an event is dropped.
- R10: If an event is waiting when the last nibble of a transfer goes out, its header follows on the very next bus slot. Otherwise the bus returns to the idle nibble.
- R11: While reset is held, `trc_sync` = 1, `trc_data` = 4'b0011, `br_ready` = 1 and `br_ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | Core offers a branch destination address this cycle |
| br_addr | input | 32 | Branch destination address |
| br_ready | output | 1 | Holding slot is empty, so an offered event will be captured |
| br_ovf | output | 1 | Sticky flag: an event was dropped |
| trc_clk | output | 1 | Forwarded trace clock at half the system rate |
| trc_sync | output | 1 | High for idle and header nibbles, low for address nibbles |
| trc_data | output | 4 | Trace data nibble |

## Verification
The main test is a sweep over all 32 bit positions. For each position the bench sends an address that differs from the reference only in that bit, then sends the reference address again. This makes every size code appear at each group boundary, so a wrong comparison width or a wrong priority order shows up as a wrong header.

A run of identical addresses exercises the one-nibble case. A sequence of pseudo-random addresses, with their high bits shared in varying amounts, mixes all four sizes and checks that the reference address is updated at the right moment.

Two events posted back to back show whether the second header follows the last nibble with no idle slot in between. Two events offered on consecutive cycles separate a correct drop-and-flag from silent loss or an overwritten slot.

// File: rtl/trace_nibble_pkg.sv
// Shared types and constants for the branch trace nibble serializer.
// Assumes a four-bit trace bus and four size groups.
package trace_nibble_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        SZ_1NIB = 2'b00,
        SZ_2NIB = 2'b01,
        SZ_4NIB = 2'b10,
        SZ_8NIB = 2'b11
    } size_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    localparam logic [1:0]       HDR_TAG  = 2'b10;
    localparam logic [NIB_W-1:0] IDLE_NIB = 4'b0011;

endpackage

// File: rtl/trace_clkdiv.sv
// Divides the system clock by two. It gives the forwarded trace clock
// and a step pulse that marks the cycle in which the bus may change.
// Assumes a synchronous active-low reset; the trace clock is low in reset.
module trace_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic trc_clk,
    output logic step
);

    logic phase_q;

    // Phase toggle: one full trace clock period every two system cycles
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign trc_clk = phase_q;
    assign step    = phase_q;  // the bus updates as the trace clock falls

    AST_TCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (trc_clk != $past(trc_clk))); // R1

endmodule

// File: rtl/trace_size_enc.sv
// Compression decision. It compares the new address with the reference
// address over three prefix widths and returns the smallest group whose
// prefix matches. An invalid reference always gives the full-width code.
module trace_size_enc
    import trace_nibble_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              ref_vld,
    output size_code_e        code
);

    localparam int N_CMP = 3;

    logic [N_CMP-1:0] hit;

    // One prefix comparator per partial group width (4, 8, 16 bits)
    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        localparam int LO = NIB_W << g;
        assign hit[g] = ref_vld &&
                        (new_addr[ADDR_W-1:LO] == ref_addr[ADDR_W-1:LO]);
    end

    // Priority pick: the narrowest matching group wins
    always_comb begin
        if (hit[0])      code = SZ_1NIB;
        else if (hit[1]) code = SZ_2NIB;
        else if (hit[2]) code = SZ_4NIB;
        else             code = SZ_8NIB;
    end

    always_comb begin
        if (!ref_vld) AST_FIRST_FULL: assert (code == SZ_8NIB); // R7
    end

endmodule

// File: rtl/trace_serializer.sv
// Bus sequencer. On each step it sends the idle nibble, a header, or the
// next address nibble, least significant first. It holds the reference
// address and refreshes it once the last nibble of a transfer is out.
// Assumes that step pulses at most every other cycle and that the event
// slot stays full until it is taken.
module trace_serializer
    import trace_nibble_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ev_vld,
    input  logic [ADDR_W-1:0] ev_addr,
    input  size_code_e        ev_code,
    output logic              ev_take,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              ref_vld,
    output logic              trc_sync,
    output logic [NIB_W-1:0]  trc_data
);

    localparam int MAX_NIB = ADDR_W / NIB_W;
    localparam int CNT_W   = $clog2(MAX_NIB + 1);

    tx_state_e         state_q;
    logic [ADDR_W-1:0] shift_q;
    logic [ADDR_W-1:0] full_q;
    logic [CNT_W-1:0]  left_q;

    // The event slot is taken only when a header can start on this step
    assign ev_take = step && (state_q == ST_IDLE) && ev_vld;

    // Sequencer: idle / header / address nibbles, plus the reference update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            shift_q  <= '0;
            full_q   <= '0;
            left_q   <= '0;
            ref_addr <= '0;
            ref_vld  <= 1'b0;
            trc_sync <= 1'b1;
            trc_data <= IDLE_NIB;
        end else if (step) begin
            case (state_q)
                ST_IDLE: begin
                    if (ev_vld) begin
                        trc_sync <= 1'b1;
                        trc_data <= {HDR_TAG, ev_code};
                        shift_q  <= ev_addr;
                        full_q   <= ev_addr;
                        left_q   <= CNT_W'(1) << ev_code;
                        state_q  <= ST_SEND;
                    end else begin
                        trc_sync <= 1'b1;
                        trc_data <= IDLE_NIB;
                    end
                end
                ST_SEND: begin
                    trc_sync <= 1'b0;
                    trc_data <= shift_q[NIB_W-1:0];
                    shift_q  <= shift_q >> NIB_W;
                    left_q   <= left_q - CNT_W'(1);
                    if (left_q == CNT_W'(1)) begin
                        ref_addr <= full_q;
                        ref_vld  <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_SYNC_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trc_sync) |-> ($past(trc_data[3:2]) == HDR_TAG)); // R3
    AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_sync && (trc_data[3:2] != HDR_TAG)) |-> (trc_data == IDLE_NIB)); // R2
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> (left_q != '0)); // R5

endmodule

// File: rtl/trace_nibble_tx.sv
// Top level of the branch trace nibble serializer. It holds one pending
// event, flags dropped events, and ties together the clock divider, the
// compression decision and the bus sequencer.
// Assumes the core offers at most one address per cycle and may ignore
// ready; an event offered while the slot is full is lost.
module trace_nibble_tx
    import trace_nibble_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_addr,
    output logic              br_ready,
    output logic              br_ovf,
    output logic              trc_clk,
    output logic              trc_sync,
    output logic [NIB_W-1:0]  trc_data
);

    logic              step;
    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;
    logic              take;
    logic [ADDR_W-1:0] ref_addr;
    logic              ref_vld;
    size_code_e        code;

    trace_clkdiv i_clkdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .trc_clk (trc_clk),
        .step    (step)
    );

    trace_size_enc #(.ADDR_W(ADDR_W)) i_size_enc (
        .new_addr (pend_addr),
        .ref_addr (ref_addr),
        .ref_vld  (ref_vld),
        .code     (code)
    );

    trace_serializer #(.ADDR_W(ADDR_W)) i_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .ev_vld   (pend_v),
        .ev_addr  (pend_addr),
        .ev_code  (code),
        .ev_take  (take),
        .ref_addr (ref_addr),
        .ref_vld  (ref_vld),
        .trc_sync (trc_sync),
        .trc_data (trc_data)
    );

    assign br_ready = ~pend_v;

    // One-entry holding slot: filled from the core, emptied by the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
        end else begin
            if (take) pend_v <= 1'b0;
            if (br_valid && !pend_v) begin
                pend_v    <= 1'b1;
                pend_addr <= br_addr;
            end
        end
    end

    // Sticky drop flag: set by any offer made while the slot is full
    always_ff @(posedge clk) begin
        if (!rst_n)                 br_ovf <= 1'b0;
        else if (br_valid && pend_v) br_ovf <= 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_ready) |=> br_ovf); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(br_ovf) |-> br_ovf); // R9
    AST_BUS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({trc_sync, trc_data}) |-> $fell(trc_clk)); // R1
    AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_ready && !$past(take)) && $past(!br_ready) |-> $stable(pend_addr)); // R8

endmodule

// File: tb/test_trace_nibble_tx.sv
module test_trace_nibble_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_addr = '0;
    logic        br_ready, br_ovf, trc_clk, trc_sync;
    logic [3:0]  trc_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] exp_q [0:255];
    bit          gapless_q [0:255];
    int          wr_i = 0;
    int          rd_i = 0;

    logic [31:0] m_ref = '0;
    bit          m_vld = 1'b0;
    int          mode = 0;
    int          n_left = 0;
    int          n_got = 0;
    logic [31:0] got = '0;
    logic [1:0]  cur_code = '0;
    int          gap = 0;
    logic [4:0]  prev_bus = '0;
    logic        prev_clk = 1'b0;

    always #5 clk = ~clk;

    trace_nibble_tx i_trace_nibble_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_valid (br_valid),
        .br_addr  (br_addr),
        .br_ready (br_ready),
        .br_ovf   (br_ovf),
        .trc_clk  (trc_clk),
        .trc_sync (trc_sync),
        .trc_data (trc_data)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic [31:0] a,
                                            input logic [31:0] r, input bit v);
        if (!v)                    return 2'b11;
        if (a[31:4]  == r[31:4])   return 2'b00;
        if (a[31:8]  == r[31:8])   return 2'b01;
        if (a[31:16] == r[31:16])  return 2'b10;
        return 2'b11;
    endfunction

    // Trace port monitor: R1 toggling and stability, frame decoding
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cyc > 8) check(trc_clk != prev_clk, "R1 toggle", trc_clk, ~prev_clk);
            if (trc_clk == 1'b1 && cyc > 8)
                check({trc_sync, trc_data} == prev_bus, "R1 stable", {trc_sync, trc_data}, prev_bus);
            if (trc_clk == 1'b1) begin
                if (mode == 0) begin
                    if (trc_sync && trc_data == 4'b0011) begin
                        gap++;
                    end else if (trc_sync && trc_data[3:2] == 2'b10) begin
                        if (rd_i >= wr_i) begin
                            check(1'b0, "R8 unexpected header", trc_data, 0);
                        end else begin
                            cur_code = exp_code(exp_q[rd_i], m_ref, m_vld);
                            check(trc_data[1:0] == cur_code, "R4/R7 size code", trc_data[1:0], cur_code);
                            if (gapless_q[rd_i])
                                check(gap == 0, "R10 gapless header", gap, 0);
                            n_left = 1 << cur_code;
                            n_got  = 0;
                            got    = '0;
                            mode   = 1;
                        end
                    end else if (!trc_sync) begin
                        check(1'b0, "R5 extra nibble", trc_data, 4'b0011);
                    end else begin
                        check(1'b0, "R2 idle pattern", trc_data, 4'b0011);
                    end
                end else begin
                    check(trc_sync == 1'b0, "R3 sync low on nibble", trc_sync, 0);
                    got = got | (32'(trc_data) << (4 * n_got));
                    n_got++;
                    if (n_got == n_left) begin
                        begin
                            logic [31:0] mask;
                            mask = (n_left == 8) ? 32'hFFFF_FFFF : ((32'h1 << (4 * n_left)) - 1);
                            check(got == (exp_q[rd_i] & mask), "R6 nibble order", got, exp_q[rd_i] & mask);
                        end
                        m_ref = exp_q[rd_i];
                        m_vld = 1'b1;
                        rd_i++;
                        mode = 0;
                        gap  = 0;
                    end
                end
            end
        end
        prev_clk = trc_clk;
        prev_bus = {trc_sync, trc_data};
    end

    // Watchdog: an expired run counts as a failure and still reports
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic send(input logic [31:0] a, input bit gl);
        @(negedge clk);
        while (!br_ready) @(negedge clk);
        exp_q[wr_i]     = a;
        gapless_q[wr_i] = gl;
        wr_i++;
        br_valid = 1'b1;
        br_addr  = a;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic drain();
        while (rd_i < wr_i || mode != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(trc_sync == 1'b1 && trc_data == 4'b0011, "R10 idle after frame",
              {trc_sync, trc_data}, 5'h13);
    endtask

    initial begin
        logic [31:0] base, lf;
        base = 32'h89AB_CDEF;
        repeat (3) @(negedge clk);
        check(trc_sync == 1'b1, "R11 sync in reset", trc_sync, 1);
        check(trc_data == 4'b0011, "R11 data in reset", trc_data, 4'b0011);
        check(br_ready == 1'b1, "R11 ready in reset", br_ready, 1);
        check(br_ovf == 1'b0, "R11 ovf in reset", br_ovf, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(trc_sync == 1'b1 && trc_data == 4'b0011, "R2 idle after reset",
              {trc_sync, trc_data}, 5'h13);

        // R7: first transfer after reset is full width
        send(base, 1'b0);
        drain();

        // R4 R5 R6: single-bit difference at every position, then back
        for (int k = 0; k < 32; k++) begin
            send(base ^ (32'h1 << k), 1'b0);
            drain();
            send(base, 1'b0);
            drain();
        end

        // R5: repeated address gives the one-nibble group
        for (int k = 0; k < 4; k++) begin
            send(base, 1'b0);
            drain();
        end

        // R10 R8: back-to-back events, second header follows with no idle gap
        send(32'h1234_5678, 1'b0);
        send(32'h1234_5690, 1'b1);
        drain();

        // R4 R7: pseudo-random mix with shared high bits
        lf = 32'hACE1_2345;
        for (int k = 0; k < 48; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            send((m_ref & ~((32'h1 << (k % 28 + 4)) - 1)) | (lf & ((32'h1 << (k % 28 + 4)) - 1)), 1'b0);
            if (k % 3 == 0) drain();
        end
        drain();

        check(br_ovf == 1'b0, "R9 no drop yet", br_ovf, 0);

        // R9 R8: two offers on consecutive cycles, the second is dropped
        @(negedge clk);
        exp_q[wr_i] = 32'h0F0F_0F0F;
        gapless_q[wr_i] = 1'b0;
        wr_i++;
        br_valid = 1'b1;
        br_addr  = 32'h0F0F_0F0F;
        @(negedge clk);
        check(br_ready == 1'b0, "R8 ready low when slot full", br_ready, 0);
        br_addr = 32'hDEAD_BEEF;
        @(negedge clk);
        br_valid = 1'b0;
        check(br_ovf == 1'b1, "R9 overflow flagged", br_ovf, 1);
        drain();
        check(br_ovf == 1'b1, "R9 overflow sticky", br_ovf, 1);
        check(rd_i == wr_i, "R8 captured events sent", rd_i, wr_i);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule